// File: doc/BRIEF.md
# Pipeline Handshake Control Unit

This block is the central controller of a linear chain of datapath register stages. It sits between a valid/ready upstream port and a valid/ready downstream port. For every stage it drives a load enable: a stage captures new contents only in a cycle where its enable is high. The controller keeps one occupancy bit per stage. From those bits, the downstream ready and the per-stage requests, it decides which stages move, which hold and which refill.

Each stage returns two request bits to the controller, and both come from registers inside the stage. The drop request marks the item the stage holds as unwanted. That item is freed without being offered downstream, which is how a decimating stage merges several inputs into one output. The hold-input request stops the stage from taking anything from its upstream neighbour. While that request is set, the stage is still re-enabled each time its own output departs, so it can produce several outputs from one input. Back-pressure from both a stalled output and a held input travels upstream stage by stage.

Top module: `pipe_handshake_ctrl`

## Requirements
- R1: After a synchronous active-high reset, all occupancy bits are clear and `out_valid` is low. With `stop_rx[0]` low, `in_ready` is high.
- R2: `in_ready` is high exactly when stage 0 can load: it is empty, or its item departs or is dropped this cycle, and `stop_rx[0]` is low. A transfer happens when `in_valid` and `in_ready` are both high, and `stage_en[0]` is high in that cycle.
- R3: `out_valid` is high when the last stage is occupied and its `stop_tx` bit is low.
- R4: While `out_valid` is high and `out_ready` is low, the enable of the last stage stays low and `out_valid` stays high in the next cycle. A stalled pipeline of N stages accepts exactly N items.
- R5: With no requests set and `out_ready` held high, one item is accepted every cycle. An item accepted at clock edge k leaves on edge k+N.
- R6: An occupied stage with `stop_tx` high frees its item in the next cycle and never presents it downstream. A 4-to-1 decimating stage emits nothing for its first three inputs.
- R7: A stage with `stop_rx` high takes no item from upstream. When it is empty it is not enabled, and the upstream item stays in place. In a 1-to-4 expanding stage with the output stalled, only two items enter a three-stage chain.
- R8: A stage that is enabled is occupied in the following cycle.
- R9: When stage 1 sums each group of four inputs and drops the three partial sums, the output carries each group's sum divided by four, in order, with none lost or repeated, under random input gaps and random back-pressure.
- R10: When stage 1 emits A, A+1, A+2, A+3 (modulo 256) for each input A, holding its input until the fourth, the output carries those four values per input, in order, with none lost or repeated, under random gaps and back-pressure.
- R11: `stage_full` shows the occupancy bit of each stage, bit i for stage i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream item offered |
| in_ready | output | 1 | Stage 0 can take an item this cycle |
| out_valid | output | 1 | Last stage presents an item |
| out_ready | input | 1 | Downstream takes the presented item |
| stop_tx | input | NUM_STAGES | Per-stage drop request, from stage registers |
| stop_rx | input | NUM_STAGES | Per-stage hold-input request, from stage registers |
| stage_en | output | NUM_STAGES | Per-stage load enable |
| stage_full | output | NUM_STAGES | Per-stage occupancy |

## Verification
The hardest case to reach is an expanding stage in the middle of a sequence that is regenerating into a stalled last stage while a further upstream item waits behind it. Here the hold-input request, the stall and the refill decision all meet in one cycle. The bench wraps the controller in three register stages whose middle stage can be switched to decimate or expand. It then offers a continuous stream while `out_ready` is held low, and counts exactly how many items are admitted. After that it releases the output, first steadily and then randomly, so that regeneration is interrupted at every point of the four-output sequence while a scoreboard checks order and count.

// File: rtl/pipe_hs_pkg.sv
`timescale 1ns/1ps
package pipe_hs_pkg;

  // Occupancy update of one stage: a load always leaves the stage occupied,
  // otherwise an item stays only if it neither moves on nor is dropped.
  function automatic logic hs_next_full(input logic held, input logic loads,
                                        input logic departs);
    return loads | (held & ~departs);
  endfunction

endpackage

// File: rtl/pipe_hs_slot.sv
`timescale 1ns/1ps
module pipe_hs_slot
  import pipe_hs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic up_avail,    // neighbour above presents an item
  input  logic dn_take_ok,  // neighbour below would take our item
  input  logic stop_tx,     // drop the held item
  input  logic stop_rx,     // refuse items from above
  output logic up_take_ok,  // we can take an item from above this cycle
  output logic dn_avail,    // we present an item below
  output logic load_en,     // stage register enable
  output logic full         // occupancy
);

  logic full_q;
  logic departs;
  logic space;
  logic take;
  logic regen;

  assign dn_avail   = full_q & ~stop_tx;
  assign departs    = full_q & (stop_tx | dn_take_ok);
  assign space      = ~full_q | departs;
  assign up_take_ok = space & ~stop_rx;
  assign take       = up_take_ok & up_avail;
  assign regen      = stop_rx & departs;
  assign load_en    = take | regen;
  assign full       = full_q;

  always_ff @(posedge clk) begin
    if (rst) full_q <= 1'b0;
    else     full_q <= hs_next_full(full_q, load_en, departs);
  end

  // R8: an enabled stage holds an item afterwards
  p_en_fills_r8: assert property (@(posedge clk) disable iff (rst)
    load_en |=> full);

  // R6: a dropped item that is not replaced leaves the stage
  p_drop_frees_r6: assert property (@(posedge clk) disable iff (rst)
    (full && stop_tx && !load_en) |=> !full);

  // R7: an empty stage that refuses input is never enabled
  p_rx_stop_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (stop_rx && !full) |-> !load_en);

endmodule

// File: rtl/pipe_handshake_ctrl.sv
`timescale 1ns/1ps
module pipe_handshake_ctrl #(
  parameter int NUM_STAGES = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  output logic                  in_ready,
  output logic                  out_valid,
  input  logic                  out_ready,
  input  logic [NUM_STAGES-1:0] stop_tx,
  input  logic [NUM_STAGES-1:0] stop_rx,
  output logic [NUM_STAGES-1:0] stage_en,
  output logic [NUM_STAGES-1:0] stage_full
);

  localparam int LAST = NUM_STAGES - 1;

  // avail_v[i]: item offered into stage i (index NUM_STAGES = output port)
  // take_v[i] : stage i would take an item (index NUM_STAGES = out_ready)
  logic [NUM_STAGES:0] avail_v;
  logic [NUM_STAGES:0] take_v;

  assign avail_v[0]          = in_valid;
  assign take_v[NUM_STAGES]  = out_ready;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_slot
    pipe_hs_slot u_slot (
      .clk        (clk),
      .rst        (rst),
      .up_avail   (avail_v[i]),
      .dn_take_ok (take_v[i+1]),
      .stop_tx    (stop_tx[i]),
      .stop_rx    (stop_rx[i]),
      .up_take_ok (take_v[i]),
      .dn_avail   (avail_v[i+1]),
      .load_en    (stage_en[i]),
      .full       (stage_full[i])
    );
  end

  assign in_ready  = take_v[0];
  assign out_valid = avail_v[NUM_STAGES];

  // R2: an accepted input loads stage 0
  p_accept_loads_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |-> stage_en[0]);

  // R2: a held first stage refuses input
  p_hold_refuses_r2: assert property (@(posedge clk) disable iff (rst)
    stop_rx[0] |-> !in_ready);

  // R4: stalled output keeps the last stage closed
  p_stall_no_en_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !stage_en[LAST]);

  // R4: stalled output stays presented
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);

  // R3: a presented item implies an occupied last stage
  p_valid_needs_full_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> stage_full[LAST]);

endmodule

// File: tb/tb_pipe_handshake_ctrl.sv
`timescale 1ns/1ps
module tb_pipe_handshake_ctrl;

  localparam int N  = 3;
  localparam int W  = 8;
  localparam int SW = W + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [N-1:0] stop_tx;
  logic [N-1:0] stop_rx;
  logic [N-1:0] stage_en;
  logic [N-1:0] stage_full;

  always #4 clk = ~clk;

  pipe_handshake_ctrl #(.NUM_STAGES(N)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .stop_tx(stop_tx),
    .stop_rx(stop_rx), .stage_en(stage_en), .stage_full(stage_full)
  );

  // ---- simple register datapath around the controller
  logic [W-1:0]  in_data = '0;
  logic [W-1:0]  s0, s2;
  logic [SW-1:0] s1;
  logic [N-1:0]  stx;
  logic          srx1;
  logic          hold0 = 1'b0;
  logic [1:0]    cnt;
  int            mode = 0;   // 0 pass, 1 decimate 4:1, 2 expand 1:4

  assign stop_tx = stx;
  assign stop_rx = {1'b0, srx1, hold0};

  always @(posedge clk) begin
    if (rst) begin
      stx <= '1; srx1 <= 1'b0; cnt <= '0;
      s0 <= '0; s1 <= '0; s2 <= '0;
    end else begin
      if (stage_en[0]) begin s0 <= in_data; stx[0] <= 1'b0; end
      if (stage_en[1]) begin
        case (mode)
          1: begin
            cnt <= cnt + 2'd1;
            s1 <= (cnt == 2'd0) ? {2'b00, s0} : s1 + {2'b00, s0};
            stx[1] <= (cnt != 2'd3);
          end
          2: begin
            cnt <= cnt + 2'd1;
            s1 <= (cnt == 2'd0) ? {2'b00, s0} : s1 + 1'b1;
            srx1 <= (cnt != 2'd3);
            stx[1] <= 1'b0;
          end
          default: begin s1 <= {2'b00, s0}; stx[1] <= 1'b0; end
        endcase
      end
      if (stage_en[2]) begin
        s2 <= (mode == 1) ? s1[SW-1:2] : s1[W-1:0];
        stx[2] <= 1'b0;
      end
    end
  end

  // ---- bookkeeping
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int first_acc = -1;
  int last_out = -1;
  int n_out = 0;
  int rmode = 1;             // 0 stall, 1 ready, 2 random
  logic [W-1:0] expq[$];
  int dsum = 0;
  int dcnt = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string mode_req();
    return (mode == 1) ? "R9" : (mode == 2) ? "R10" : "R5";
  endfunction

  task automatic expect_item(input logic [W-1:0] v);
    case (mode)
      1: begin
        dsum += int'(v); dcnt++;
        if (dcnt == 4) begin
          expq.push_back(W'(dsum >> 2));
          dsum = 0; dcnt = 0;
        end
      end
      2: for (int k = 0; k < 4; k++) expq.push_back(v + W'(k));
      default: expq.push_back(v);
    endcase
  endtask

  // monitor: drives out_ready, compares leaving items
  always begin
    @(negedge clk);
    case (rmode)
      0: out_ready = 1'b0;
      1: out_ready = 1'b1;
      default: out_ready = ($urandom % 100) < 55;
    endcase
    #2;
    if (!rst) begin
      if (out_valid && !out_ready && stage_en[N-1])
        chk(1'b0, "R4", 1, 0);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) chk(1'b0, mode_req(), int'(s2), -1);
        else begin
          logic [W-1:0] e;
          e = expq.pop_front();
          chk(s2 == e, mode_req(), int'(s2), int'(e));
        end
        last_out = cyc + 1;
        n_out++;
      end
    end
  end

  task automatic offer(input int cycles, input int pct, output int accepted);
    accepted = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      in_valid = ($urandom % 100) < pct;
      in_data  = W'($urandom);
      #2;
      if (in_valid && in_ready) begin
        expect_item(in_data);
        if (first_acc < 0) first_acc = cyc + 1;
        accepted++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    rmode = 1;
    for (int i = 0; i < 600 && (expq.size() != 0 || stage_full != '0); i++)
      @(negedge clk);
    #3;
    chk(expq.size() == 0, mode_req(), expq.size(), 0);
  endtask

  task automatic reset_dut(input int m);
    @(negedge clk);
    rst = 1'b1; mode = m; dsum = 0; dcnt = 0; in_valid = 1'b0;
    expq.delete();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #3;
    chk(stage_full == '0, "R1 R11 occupancy", int'(stage_full), 0);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int acc;
    int n0;
    // pass mode, full throughput
    reset_dut(0);
    rmode = 1; first_acc = -1;
    offer(8, 100, acc);
    chk(acc == 8, "R2 R5 one per cycle", acc, 8);
    drain();
    chk(last_out - first_acc == 7 + N, "R5 latency", last_out - first_acc, 7 + N);

    // stalled output
    rmode = 0;
    offer(10, 100, acc);
    chk(acc == N, "R4 stall admits N", acc, N);
    #1;
    chk(out_valid == 1'b1, "R3 R4 held valid", int'(out_valid), 1);
    chk(in_ready == 1'b0, "R2 stall ready", int'(in_ready), 0);
    chk(stage_full == '1, "R11 all full", int'(stage_full), 7);
    drain();

    // random traffic
    rmode = 2;
    offer(300, 60, acc);
    drain();

    // hold-input on stage 0 while empty
    @(negedge clk); hold0 = 1'b1;
    offer(5, 100, acc);
    chk(acc == 0, "R7 hold refuses", acc, 0);
    chk(stage_full[0] == 1'b0, "R7 empty held stage", int'(stage_full[0]), 0);
    @(negedge clk); hold0 = 1'b0;
    #3;
    chk(in_ready == 1'b1, "R2 ready after release", int'(in_ready), 1);

    // decimation
    reset_dut(1);
    rmode = 1; n0 = n_out;
    offer(3, 100, acc);
    repeat (6) @(negedge clk);
    chk(n_out == n0, "R6 partial sums dropped", n_out - n0, 0);
    offer(1, 100, acc);
    drain();
    chk(n_out == n0 + 1, "R6 R9 one per four", n_out - n0, 1);
    rmode = 2;
    offer(400, 70, acc);
    drain();

    // expansion
    reset_dut(2);
    rmode = 0;
    offer(10, 100, acc);
    chk(acc == 2, "R7 expand back-pressure", acc, 2);
    n0 = n_out;
    drain();
    chk(n_out - n0 == 8, "R10 four per input", n_out - n0, 8);
    rmode = 2;
    offer(300, 50, acc);
    drain();
    chk(stage_full == '0, "R11 drained", int'(stage_full), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule